// File: doc/BRIEF.md
# SECDED Protected Write Path with Read-Modify-Write

This block sits between a requester and one memory channel whose stored words hold 64 data bits and 8 check bits. When protection is on, a full 8-byte write is encoded and forwarded in one step. A write that enables fewer than 8 bytes becomes an atomic sequence: read the stored word, correct it, merge the new bytes in, re-encode, and write the whole word back. Reads return corrected data and report whether an error was corrected or could not be corrected.

When protection is off, the block passes data straight through. Writes keep their byte mask, no check bits are produced, and reads come back raw. The protection switch is sampled when each request is accepted. The block stalls new requests while a read-modify-write is in flight. A read-modify-write whose read returns an uncorrectable word is abandoned, leaving memory untouched, and the block raises an error pulse.

Top module: `ecc_wr_path`

## Requirements
- R1: After reset, req_ready is 1 and mem_valid, rsp_valid, rsp_ce, rsp_ue, rmw_fixed and rmw_abort are all 0.
- R2: With protection on, a write with all 8 byte enables set is driven on the memory side one cycle after acceptance, with mem_be = 9'h1FF and mem_wdata = {P, H[6:0], D[63:0]}. Hamming positions 1..71 that are not powers of two are given to data bits 0..63 in increasing order. H[k] is the XOR of the data bits whose position has bit k set. P is the XOR of bits 70:0.
- R3: With protection off, any write is driven one cycle after acceptance with mem_wdata = {8'h00, data} and mem_be = {1'b0, byte enables}. req_ready stays 1.
- R4: With protection on, a write with fewer than 8 byte enables becomes a read of the same address, followed by a write of the encoded word. In that word, enabled bytes come from the request and the other bytes come from the corrected stored word, with mem_be = 9'h1FF.
- R5: When the read-modify-write read holds a single-bit error, the written word is built from the corrected data. rmw_fixed pulses for one cycle together with the write command.
- R6: When the read-modify-write read holds an uncorrectable error, no write is issued, rmw_abort pulses for one cycle and the stored word keeps its old value.
- R7: With protection on, a read answers one cycle after mem_rvalid with rsp_valid. rsp_rdata holds corrected data. rsp_ce marks a single-bit error in any of the 72 bits, and rsp_ue marks a double-bit error. The two flags are never both set.
- R8: With protection off, a read returns the stored data bits unchanged and never sets rsp_ce or rsp_ue, even when the stored word is corrupted.
- R9: req_ready is low from the cycle after a read-modify-write is accepted until its write command has been issued. That is 4 cycles with a one-cycle read latency, or 3 cycles when the sequence is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_on | input | 1 | Protection enable, sampled at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| rsp_ce | output | 1 | Read had a corrected error |
| rsp_ue | output | 1 | Read had an uncorrectable error |
| rmw_fixed | output | 1 | Read-modify-write corrected a single-bit error |
| rmw_abort | output | 1 | Read-modify-write abandoned on an uncorrectable error |
| mem_valid | output | 1 | Memory command valid |
| mem_write | output | 1 | Memory command is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 72 | Stored word: data plus check bits |
| mem_be | output | 9 | Lane enables; lane 8 covers the check byte |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 72 | Memory read data |

## Verification
The hardest cases are the read-modify-write sequences whose read phase meets a corrupted word. The stored contents stay correct, so the error has to appear only on the read return path. The bench's memory model applies an XOR mask to exactly one read response and then clears it. A single-bit mask checks that the merged write-back carries corrected data. A two-bit mask checks that the write is dropped, and a clean read afterwards confirms that the old contents survived.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
    localparam int DW = 64;
    localparam int NB = DW / 8;
    localparam int HB = 7;
    localparam int CW = HB + 1;
    localparam int WW = DW + CW;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_WAIT  = 3'd2,
        S_MERGE = 3'd3,
        S_WRITE = 3'd4,
        S_RDW   = 3'd5
    } phase_e;

    // Hamming position of data bit idx: positions 1..WW-1 skipping powers of two
    function automatic logic [HB-1:0] data_pos(input int idx);
        int n;
        logic [HB-1:0] r;
        n = 0;
        r = '0;
        for (int p = 1; p < WW; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) r = HB'(p);
                n++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_rmw_pkg::*;
(
    input  logic [DW-1:0] din,
    output logic [CW-1:0] chk
);
    logic [HB-1:0] ham;
    logic [HB-1:0] pos;

    always_comb begin
        ham = '0;
        pos = '0;
        for (int i = 0; i < DW; i++) begin
            pos = data_pos(i);
            for (int k = 0; k < HB; k++) begin
                if (pos[k]) ham[k] = ham[k] ^ din[i];
            end
        end
        chk = {(^din) ^ (^ham), ham};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_rmw_pkg::*;
(
    input  logic [WW-1:0] cw,
    output logic [DW-1:0] dout,
    output logic          ce,
    output logic          ue
);
    logic [CW-1:0] fresh;
    logic [HB-1:0] syn;
    logic          odd;
    logic          in_range;

    secded_enc u_enc (
        .din (cw[DW-1:0]),
        .chk (fresh)
    );

    always_comb begin
        syn      = fresh[HB-1:0] ^ cw[DW+HB-1:DW];
        odd      = cw[WW-1] ^ fresh[HB] ^ (^syn);
        in_range = (syn <= HB'(WW - 1));
        ce       = odd && in_range;
        ue       = (!odd && (syn != '0)) || (odd && !in_range);
        for (int i = 0; i < DW; i++) begin
            dout[i] = cw[i] ^ (ce && (syn == data_pos(i)));
        end
    end
endmodule

// File: rtl/byte_merge.sv
module byte_merge
    import ecc_rmw_pkg::*;
(
    input  logic [DW-1:0] old_w,
    input  logic [DW-1:0] new_w,
    input  logic [NB-1:0] be,
    output logic [DW-1:0] out_w
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign out_w[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    end
endmodule

// File: rtl/ecc_wr_path.sv
module ecc_wr_path
    import ecc_rmw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ecc_on,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_be,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_ce,
    output logic          rsp_ue,
    output logic          rmw_fixed,
    output logic          rmw_abort,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic [NB:0]   mem_be,
    input  logic          mem_rvalid,
    input  logic [WW-1:0] mem_rdata
);
    typedef struct packed {
        phase_e        st;
        logic          ecc;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [NB-1:0] be;
        logic [DW-1:0] fix;
        logic          fce;
        logic          fue;
        logic          mv;
        logic          mw;
        logic [AW-1:0] ma;
        logic [WW-1:0] md;
        logic [NB:0]   mbe;
        logic          rv;
        logic [DW-1:0] rd;
        logic          rce;
        logic          rue;
        logic          fixp;
        logic          abp;
    } regs_t;

    regs_t         q, d;
    logic [DW-1:0] merged;
    logic [DW-1:0] enc_in;
    logic [CW-1:0] enc_chk;
    logic [DW-1:0] dec_data;
    logic          dec_ce;
    logic          dec_ue;
    logic          accept;
    logic          partial;

    byte_merge u_merge (
        .old_w (q.fix),
        .new_w (q.wdata),
        .be    (q.be),
        .out_w (merged)
    );

    assign enc_in = (q.st == S_MERGE) ? merged : req_wdata;

    secded_enc u_enc (
        .din (enc_in),
        .chk (enc_chk)
    );

    secded_dec u_dec (
        .cw   (mem_rdata),
        .dout (dec_data),
        .ce   (dec_ce),
        .ue   (dec_ue)
    );

    assign accept  = req_valid && (q.st == S_IDLE);
    assign partial = (req_be != '1);

    always_comb begin
        d      = q;
        d.mv   = 1'b0;
        d.mw   = 1'b0;
        d.rv   = 1'b0;
        d.rce  = 1'b0;
        d.rue  = 1'b0;
        d.fixp = 1'b0;
        d.abp  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (accept) begin
                    d.ecc  = cfg_ecc_on;
                    d.addr = req_addr;
                    if (req_write) begin
                        if (cfg_ecc_on && partial) begin
                            d.wdata = req_wdata;
                            d.be    = req_be;
                            d.st    = S_READ;
                        end else begin
                            d.mv = 1'b1;
                            d.mw = 1'b1;
                            d.ma = req_addr;
                            if (cfg_ecc_on) begin
                                d.md  = {enc_chk, req_wdata};
                                d.mbe = '1;
                            end else begin
                                d.md  = {{CW{1'b0}}, req_wdata};
                                d.mbe = {1'b0, req_be};
                            end
                        end
                    end else begin
                        d.mv = 1'b1;
                        d.ma = req_addr;
                        d.st = S_RDW;
                    end
                end
            end
            S_READ: begin
                d.mv = 1'b1;
                d.ma = q.addr;
                d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    d.fix = dec_data;
                    d.fce = dec_ce;
                    d.fue = dec_ue;
                    d.st  = S_MERGE;
                end
            end
            S_MERGE: begin
                if (q.fue) begin
                    d.abp = 1'b1;
                    d.st  = S_IDLE;
                end else begin
                    d.mv   = 1'b1;
                    d.mw   = 1'b1;
                    d.ma   = q.addr;
                    d.md   = {enc_chk, merged};
                    d.mbe  = '1;
                    d.fixp = q.fce;
                    d.st   = S_WRITE;
                end
            end
            S_WRITE: begin
                d.st = S_IDLE;
            end
            S_RDW: begin
                if (mem_rvalid) begin
                    d.rv = 1'b1;
                    if (q.ecc) begin
                        d.rd  = dec_data;
                        d.rce = dec_ce;
                        d.rue = dec_ue;
                    end else begin
                        d.rd = mem_rdata[DW-1:0];
                    end
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == S_IDLE);
    assign rsp_valid = q.rv;
    assign rsp_rdata = q.rd;
    assign rsp_ce    = q.rce;
    assign rsp_ue    = q.rue;
    assign rmw_fixed = q.fixp;
    assign rmw_abort = q.abp;
    assign mem_valid = q.mv;
    assign mem_write = q.mw;
    assign mem_addr  = q.ma;
    assign mem_wdata = q.md;
    assign mem_be    = q.mbe;
endmodule

// File: rtl/ecc_wr_path_chk.sv
module ecc_wr_path_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_ecc_on,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [7:0] req_be,
    input logic       rsp_valid,
    input logic       rsp_ce,
    input logic       rsp_ue,
    input logic       rmw_fixed,
    input logic       rmw_abort,
    input logic       mem_valid,
    input logic       mem_write,
    input logic [8:0] mem_be
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && cfg_ecc_on && req_be == 8'hFF)
        |=> (mem_valid && mem_write && mem_be == 9'h1FF));

    a_r3_bypass_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && !cfg_ecc_on)
        |=> (mem_valid && mem_write && req_ready && mem_be == {1'b0, $past(req_be)}));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && cfg_ecc_on && req_be != 8'hFF) |=> (!req_ready && !mem_valid));

    a_r5_fix_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_fixed |-> (mem_valid && mem_write && mem_be == 9'h1FF));

    a_r6_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_abort |-> !(mem_valid && mem_write));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ce || rsp_ue) |-> (rsp_valid && !(rsp_ce && rsp_ue)));

    a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rmw_fixed, rmw_abort, rsp_valid}));
endmodule

bind ecc_wr_path ecc_wr_path_chk u_chk (.*);

// File: tb/ecc_wr_path_test.sv
module ecc_wr_path_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_ecc_on = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_be = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          rsp_ce, rsp_ue, rmw_fixed, rmw_abort;
    logic          mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;
    logic [8:0]    mem_be;
    logic          mem_rvalid = 1'b0;
    logic [71:0]   mem_rdata = '0;

    always #2.5 clk = ~clk;

    ecc_wr_path #(.AW(AW)) uut (.*);

    int total = 0;
    int bad = 0;
    int fix_cnt = 0;
    int ab_cnt = 0;
    logic [71:0] flip_next = '0;
    logic [71:0] stor [int];
    logic [63:0] shadow [int];
    logic [AW+81-1:0] exp_wr [$];
    string            exp_wr_tag [$];
    logic [66:0]      exp_rsp [$];
    string            exp_rsp_tag [$];

    task automatic chk(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [71:0] spec_enc(input logic [63:0] dd);
        logic [6:0] h;
        int di;
        h = '0;
        di = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < 7; k++) if (p[k]) h[k] ^= dd[di];
                di++;
            end
        end
        return {(^h) ^ (^dd), h, dd};
    endfunction

    function automatic logic [63:0] spec_merge(input logic [63:0] o, input logic [63:0] n,
                                               input logic [7:0] be);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    // memory model: one-cycle read latency, single-shot corruption mask on reads
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rst_n && mem_valid) begin
            if (mem_write) begin
                logic [71:0] w;
                w = stor.exists(int'(mem_addr)) ? stor[int'(mem_addr)] : '0;
                for (int b = 0; b < 9; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
                stor[int'(mem_addr)] = w;
            end else begin
                mem_rdata = (stor.exists(int'(mem_addr)) ? stor[int'(mem_addr)] : '0) ^ flip_next;
                flip_next = '0;
                mem_rvalid = 1'b1;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_write) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R6", $sformatf("unexpected write addr=%0h data=%h exp=none", mem_addr, mem_wdata));
                end else begin
                    logic [AW+81-1:0] e;
                    string t;
                    e = exp_wr.pop_front();
                    t = exp_wr_tag.pop_front();
                    chk({mem_addr, mem_wdata, mem_be} == e, t,
                        $sformatf("write act=%h exp=%h", {mem_addr, mem_wdata, mem_be}, e));
                end
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) begin
                    chk(1'b0, "R7", $sformatf("unexpected response %h exp=none", rsp_rdata));
                end else begin
                    logic [66:0] e;
                    string t;
                    e = exp_rsp.pop_front();
                    t = exp_rsp_tag.pop_front();
                    chk({rsp_ce, rsp_ue} == e[1:0] && (!e[66] || rsp_rdata == e[65:2]), t,
                        $sformatf("read act=%h ce=%0b ue=%0b exp=%h ce=%0b ue=%0b",
                                  rsp_rdata, rsp_ce, rsp_ue, e[65:2], e[1], e[0]));
                end
            end
            if (rmw_fixed) fix_cnt++;
            if (rmw_abort) ab_cnt++;
        end
    end

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [63:0] dd,
                         input logic [7:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = dd;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        int n;
        n = 0;
        while ((!req_ready || exp_wr.size() != 0 || exp_rsp.size() != 0) && n < 50) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    // write driver: pushes the expected memory command, then drives the request
    task automatic wr(input logic [AW-1:0] a, input logic [63:0] dd, input logic [7:0] be,
                      input logic [71:0] flip, input bit dbl, input string tag);
        logic [63:0] old;
        logic [63:0] m;
        int lows;
        bit rmw;
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
        rmw = cfg_ecc_on && (be != 8'hFF);
        if (!cfg_ecc_on) begin
            exp_wr.push_back({a, 8'h00, dd, 1'b0, be});
            exp_wr_tag.push_back(tag);
            shadow[int'(a)] = spec_merge(old, dd, be);
        end else if (!rmw) begin
            exp_wr.push_back({a, spec_enc(dd), 9'h1FF});
            exp_wr_tag.push_back(tag);
            shadow[int'(a)] = dd;
        end else if (!dbl) begin
            m = spec_merge(old, dd, be);
            exp_wr.push_back({a, spec_enc(m), 9'h1FF});
            exp_wr_tag.push_back(tag);
            shadow[int'(a)] = m;
        end
        flip_next = flip;
        issue(1'b1, a, dd, be);
        if (rmw) begin
            lows = 0;
            while (!req_ready && lows < 20) begin
                lows++;
                @(negedge clk);
            end
            // R9: stall length
            chk(lows == (dbl ? 3 : 4), "R9", $sformatf("ready low cycles act=%0d exp=%0d", lows, dbl ? 3 : 4));
        end else begin
            chk(req_ready == 1'b1, tag, $sformatf("ready after direct write act=%0b exp=1", req_ready));
        end
        settle();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [71:0] flip, input logic [63:0] ed,
                      input bit care, input bit ece, input bit eue, input string tag);
        exp_rsp.push_back({care, ed, ece, eue});
        exp_rsp_tag.push_back(tag);
        flip_next = flip;
        issue(1'b0, a, '0, '0);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f0, a0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !mem_valid && !rsp_valid && !rsp_ce && !rsp_ue && !rmw_fixed && !rmw_abort,
            "R1", $sformatf("reset outputs act=%b exp=1000000",
                            {req_ready, mem_valid, rsp_valid, rsp_ce, rsp_ue, rmw_fixed, rmw_abort}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_valid, "R1", $sformatf("after reset ready=%0b mem_valid=%0b exp=1/0",
                                                     req_ready, mem_valid));

        // R2: full encoded writes
        wr(0, 64'h0123_4567_89AB_CDEF, 8'hFF, '0, 0, "R2");
        wr(1, 64'hFFFF_0000_FFFF_0000, 8'hFF, '0, 0, "R2");
        wr(2, 64'h0, 8'hFF, '0, 0, "R2");
        wr(3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, '0, 0, "R2");

        // R7: protected reads, clean and single-bit flips in data, check and parity bits
        rd(0, '0, 64'h0123_4567_89AB_CDEF, 1, 0, 0, "R7");
        rd(1, 72'h1 << 5, 64'hFFFF_0000_FFFF_0000, 1, 1, 0, "R7");
        rd(2, 72'h1 << 70, 64'h0, 1, 1, 0, "R7");
        rd(3, 72'h1 << 71, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, "R7");
        rd(0, (72'h1 << 3) | (72'h1 << 40), 64'h0, 0, 0, 1, "R7");

        // R4: partial writes with clean read phase
        wr(1, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F, '0, 0, "R4");
        rd(1, '0, 64'hFFFF_0000_AAAA_AAAA, 1, 0, 0, "R4");
        wr(0, 64'h5555_5555_5555_5555, 8'h00, '0, 0, "R4");
        rd(0, '0, 64'h0123_4567_89AB_CDEF, 1, 0, 0, "R4");

        // R5: single-bit error in read phase is corrected in the write-back
        f0 = fix_cnt;
        wr(2, 64'h1122_3344_5566_7788, 8'h81, 72'h1 << 17, 0, "R5");
        chk(fix_cnt == f0 + 1, "R5", $sformatf("rmw_fixed pulses act=%0d exp=%0d", fix_cnt - f0, 1));
        rd(2, '0, 64'h1100_0000_0000_0088, 1, 0, 0, "R5");

        // R6: double-bit error in read phase aborts the write
        a0 = ab_cnt;
        f0 = fix_cnt;
        wr(3, 64'h0, 8'h10, (72'h1 << 2) | (72'h1 << 9), 1, "R6");
        chk(ab_cnt == a0 + 1 && fix_cnt == f0, "R6",
            $sformatf("abort pulses act=%0d exp=1 fixed act=%0d exp=0", ab_cnt - a0, fix_cnt - f0));
        rd(3, '0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, "R6");

        // R3: protection off, byte-masked pass-through without stall
        cfg_ecc_on = 1'b0;
        wr(10, 64'hDEAD_BEEF_CAFE_F00D, 8'h81, '0, 0, "R3");
        wr(11, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF, '0, 0, "R3");

        // R8: raw reads ignore corruption and raise no flags
        rd(10, 72'h3 | (72'h1 << 66), 64'hDE00_0000_0000_000D ^ 64'h3, 1, 0, 0, "R8");
        rd(11, (72'h1 << 8) | (72'h1 << 20), 64'h0F0F_0F0F_0F0F_0F0F ^ 64'h0010_0100, 1, 0, 0, "R8");

        repeat (5) @(negedge clk);
        chk(exp_wr.size() == 0 && exp_rsp.size() == 0, "R4",
            $sformatf("pending items act=%0d exp=0", exp_wr.size() + exp_rsp.size()));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule